// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block erases a contiguous range of erase blocks on a NAND device through a byte-wide command, address and read port. For each block in the range it turns the block index into a page row address, issues the erase-setup opcode, the row address bytes and the erase-confirm opcode. It then polls the device with status reads until the ready bit is seen or a poll limit runs out. A final status read decides whether the block passed.

The device geometry comes from an earlier probe: the log2 of pages per block, the page class (small or large page), the address-cycle setting and the block count. A range with a negative first index, a last index past the end, or a first index above the last is refused before anything is driven on the port. Each block that passes raises a one-cycle strobe that carries its index. When the range ends, a one-cycle `done` pulse carries a result code.

Top module: `nand_erase_seq`

## Requirements
- R1: A start whose first index has its top bit set (negative), whose last index is greater than or equal to `num_blocks`, or whose first index exceeds the last index ends in the cycle after start with `done`=1 and `result`=3, and drives nothing on the port (`bus_op` stays 0).
- R2: For each block the port carries, in consecutive cycles, a command (`bus_op`=1) of 0x60, then the row address bytes as address cycles (`bus_op`=2) least significant byte first, then a command of 0xD0. No column bytes are sent.
- R3: The row address of a block is its index shifted left by `ppb_log2`, which is the block index times the pages per block.
- R4: With `large_page`=0 the row phase has 2 bytes when `addr_cycles` is at most 3, 3 bytes when it is 4, and 4 bytes when it is 5 or more.
- R5: With `large_page`=1 the row phase has 2 bytes when `addr_cycles` is at most 4, and 3 bytes when it is 5 or more.
- R6: After the confirm command the block polls with a command of 0x70 followed by a read cycle (`bus_op`=3). It repeats until a read returns bit 6 (0x40) set. It then issues one more 0x70 command and read, and that final status is judged on bit 0 (0x01, fail).
- R7: If `POLL_LIMIT` consecutive polls return not-ready, the range stops after the last of them with `done`=1 and `result`=1, and no further bus cycles follow.
- R8: If the final status of a block has bit 0 set, the range stops with `done`=1 and `result`=2. No erased strobe is raised for that block and no later block is touched.
- R9: Each block whose final status passes raises `erased_valid` for one cycle with `erased_blk` equal to its index, in the cycle after that status read. Blocks are processed in ascending order.
- R10: When the last block of the range passes, `done` pulses for one cycle with `result`=0, and that cycle also carries the erased strobe for the last block.
- R11: A `start` pulse while a range is in progress is ignored: the port sequence and the result are those of the range already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin erasing the range given on the argument inputs |
| first_blk | input | BLK_W | First block index (top bit set means negative) |
| last_blk | input | BLK_W | Last block index, inclusive |
| num_blocks | input | BLK_W | Number of blocks on the device |
| ppb_log2 | input | 5 | log2 of pages per erase block |
| large_page | input | 1 | 1 for the large-page address format |
| addr_cycles | input | 3 | Address-cycle setting from probe |
| busy | output | 1 | A range is in progress |
| done | output | 1 | One-cycle end-of-range pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 fail, 3 bad arguments; valid with done |
| erased_valid | output | 1 | One-cycle strobe: a block passed its erase |
| erased_blk | output | BLK_W | Index of the block that passed |
| bus_op | output | 2 | Port cycle: 0 idle, 1 command, 2 address, 3 read |
| bus_data | output | 8 | Opcode or address byte for command and address cycles |
| bus_rdata | input | 8 | Status byte returned during a read cycle |

## Verification
A wrong address byte count or a wrong shift of the block index shows up on the port within a few cycles of the setup command, as a misplaced 0xD0 or a bad row byte. A poll counter that is off by one changes the number of 0x70/read pairs before a timeout, and the first missing or extra pair is visible. A wrong block counter appears at the next erased strobe or as an extra setup command after the final block. A status bit tested in the wrong place shows as an early or late end of polling, or as a failure reported on a clean status.

// File: rtl/nand_erase_seq.sv
module nand_erase_seq #(
  parameter int BLK_W      = 16,
  parameter int POLL_LIMIT = 1000,
  parameter int CNT_W      = $clog2(POLL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] first_blk,
  input  logic [BLK_W-1:0] last_blk,
  input  logic [BLK_W-1:0] num_blocks,
  input  logic [4:0]       ppb_log2,
  input  logic             large_page,
  input  logic [2:0]       addr_cycles,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic             erased_valid,
  output logic [BLK_W-1:0] erased_blk,
  output logic [1:0]       bus_op,
  output logic [7:0]       bus_data,
  input  logic [7:0]       bus_rdata
);
  localparam logic [7:0] OPC_SETUP   = 8'h60;
  localparam logic [7:0] OPC_CONFIRM = 8'hD0;
  localparam logic [7:0] OPC_STATUS  = 8'h70;
  localparam int         RDY_BIT     = 6;
  localparam int         FAIL_BIT    = 0;
  localparam int         ROW_W       = 32;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_CONFIRM, S_PCMD, S_PRD, S_SCMD, S_SRD
  } state_t;

  state_t           state;
  logic [BLK_W-1:0] blk, last_r;
  logic [4:0]       ppb_r;
  logic             large_r;
  logic [2:0]       cyc_r;
  logic [1:0]       idx;
  logic [CNT_W-1:0] polls;
  logic [2:0]       nbytes;
  logic [ROW_W-1:0] row, row_sh;
  logic             bad_args;

  assign bad_args = first_blk[BLK_W-1] || (last_blk >= num_blocks) || (first_blk > last_blk);

  assign nbytes = large_r ? ((cyc_r >= 3'd5) ? 3'd3 : 3'd2)
                          : ((cyc_r >= 3'd5) ? 3'd4 : (cyc_r >= 3'd4) ? 3'd3 : 3'd2);

  assign row    = ROW_W'(blk) << ppb_r;
  assign row_sh = row >> {idx, 3'b000};

  assign busy = (state != S_IDLE);

  always_comb begin
    bus_op   = 2'd0;
    bus_data = 8'h00;
    case (state)
      S_SETUP:         begin bus_op = 2'd1; bus_data = OPC_SETUP;   end
      S_ADDR:          begin bus_op = 2'd2; bus_data = row_sh[7:0]; end
      S_CONFIRM:       begin bus_op = 2'd1; bus_data = OPC_CONFIRM; end
      S_PCMD, S_SCMD:  begin bus_op = 2'd1; bus_data = OPC_STATUS;  end
      S_PRD, S_SRD:    bus_op = 2'd3;
      default:         ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      blk          <= '0;
      last_r       <= '0;
      ppb_r        <= '0;
      large_r      <= 1'b0;
      cyc_r        <= '0;
      idx          <= '0;
      polls        <= '0;
      done         <= 1'b0;
      result       <= 2'd0;
      erased_valid <= 1'b0;
      erased_blk   <= '0;
    end else begin
      done         <= 1'b0;
      erased_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (bad_args) begin
            done   <= 1'b1;
            result <= 2'd3;
          end else begin
            blk     <= first_blk;
            last_r  <= last_blk;
            ppb_r   <= ppb_log2;
            large_r <= large_page;
            cyc_r   <= addr_cycles;
            state   <= S_SETUP;
          end
        end
        S_SETUP: begin
          idx   <= '0;
          state <= S_ADDR;
        end
        S_ADDR: begin
          if ({1'b0, idx} == nbytes - 3'd1) state <= S_CONFIRM;
          else idx <= idx + 2'd1;
        end
        S_CONFIRM: begin
          polls <= '0;
          state <= S_PCMD;
        end
        S_PCMD: state <= S_PRD;
        S_PRD: begin
          if (bus_rdata[RDY_BIT]) state <= S_SCMD;
          else if (polls == CNT_W'(POLL_LIMIT - 1)) begin
            done   <= 1'b1;
            result <= 2'd1;
            state  <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
            state <= S_PCMD;
          end
        end
        S_SCMD: state <= S_SRD;
        S_SRD: begin
          if (bus_rdata[FAIL_BIT]) begin
            done   <= 1'b1;
            result <= 2'd2;
            state  <= S_IDLE;
          end else begin
            erased_valid <= 1'b1;
            erased_blk   <= blk;
            if (blk == last_r) begin
              done   <= 1'b1;
              result <= 2'd0;
              state  <= S_IDLE;
            end else begin
              blk   <= blk + 1'b1;
              state <= S_SETUP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_erase_seq_chk #(
  parameter int BLK_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [1:0]       result,
  input logic             erased_valid,
  input logic [1:0]       bus_op,
  input logic [7:0]       bus_data
);
  // R2
  addr_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd2) |-> ($past(bus_op) == 2'd1 || $past(bus_op) == 2'd2));

  // R2
  active_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op != 2'd0) |-> busy);

  // R9
  erased_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erased_valid |-> ($past(bus_op) == 2'd3));

  // R1
  badarg_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd3) |-> ($past(bus_op) == 2'd0 && !busy));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  read_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd3) |-> ($past(bus_op) == 2'd1 && $past(bus_data) == 8'h70));
endmodule

bind nand_erase_seq nand_erase_seq_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .erased_valid(erased_valid), .bus_op(bus_op), .bus_data(bus_data)
);

// File: tb/nand_erase_seq_tb.sv
module nand_erase_seq_tb;
  localparam int  BLK_W = 16;
  localparam int  LIMIT = 1000;
  localparam time TCLK  = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [BLK_W-1:0] first_blk = '0, last_blk = '0, num_blocks = 16'h2000;
  logic [4:0]       ppb_log2 = '0;
  logic             large_page = 1'b0;
  logic [2:0]       addr_cycles = 3'd3;
  logic             busy, done, erased_valid;
  logic [1:0]       result, bus_op;
  logic [BLK_W-1:0] erased_blk;
  logic [7:0]       bus_data, bus_rdata;

  always #(TCLK/2) clk = ~clk;

  nand_erase_seq #(.BLK_W(BLK_W), .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk),
    .last_blk(last_blk), .num_blocks(num_blocks), .ppb_log2(ppb_log2),
    .large_page(large_page), .addr_cycles(addr_cycles), .busy(busy),
    .done(done), .result(result), .erased_valid(erased_valid),
    .erased_blk(erased_blk), .bus_op(bus_op), .bus_data(bus_data),
    .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  int ers_q[$];
  string cur_req = "R2";

  int busy_n = 0, fail_nth = 0, nconf = 0, polls_left = 0;
  bit failing = 0, dec_pend = 0;

  assign bus_rdata = (polls_left == 0) ? (8'h40 | (failing ? 8'h01 : 8'h00)) : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (dec_pend) begin
      polls_left--;
      dec_pend = 0;
    end
    if (rst_n && bus_op != 2'd0) begin
      if (exp_q.size() == 0) chk(0, cur_req, {bus_op, bus_data}, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        if (bus_op == 2'd3) chk(e[9:8] == 2'd3, cur_req, {bus_op, bus_data}, e);
        else chk(e == int'({bus_op, bus_data}), cur_req, {bus_op, bus_data}, e);
      end
      if (bus_op == 2'd1 && bus_data == 8'hD0) begin
        nconf++;
        polls_left = busy_n;
        failing = (nconf == fail_nth);
      end
      if (bus_op == 2'd3 && polls_left > 0) dec_pend = 1;
    end
    if (rst_n && erased_valid) begin
      if (ers_q.size() == 0) chk(0, "R9", erased_blk, -1);
      else begin
        int b;
        b = ers_q.pop_front();
        chk(erased_blk == b[BLK_W-1:0], "R9", erased_blk, b);
      end
    end
  end

  function automatic int nbytes_of(input bit lg, input int cyc);
    if (lg) return (cyc >= 5) ? 3 : 2;
    return (cyc >= 5) ? 4 : (cyc >= 4) ? 3 : 2;
  endfunction

  task automatic run(input int f, input int l, input int ppb, input bit lg, input int cyc,
                     input int bn, input int fn, input int exp_res, input string req,
                     input bit poke);
    int nb, polls;
    bit stop;
    cur_req = req;
    busy_n = bn; fail_nth = fn; nconf = 0; failing = 0;
    stop = 0;
    if (exp_res != 3) begin
      for (int b = f; b <= l && !stop; b++) begin
        longint unsigned row;
        row = longint'(b) << ppb;
        exp_q.push_back({2'd1, 8'h60});
        nb = nbytes_of(lg, cyc);
        for (int k = 0; k < nb; k++) exp_q.push_back({2'd2, 8'(row >> (8*k))});
        exp_q.push_back({2'd1, 8'hD0});
        polls = (bn >= LIMIT) ? LIMIT : bn + 1;
        for (int p = 0; p < polls; p++) begin
          exp_q.push_back({2'd1, 8'h70});
          exp_q.push_back({2'd3, 8'h00});
        end
        if (bn >= LIMIT) stop = 1;
        else begin
          exp_q.push_back({2'd1, 8'h70});
          exp_q.push_back({2'd3, 8'h00});
          if (b - f + 1 == fn) stop = 1;
          else ers_q.push_back(b);
        end
      end
    end
    @(negedge clk);
    first_blk = BLK_W'(f); last_blk = BLK_W'(l); ppb_log2 = 5'(ppb);
    large_page = lg; addr_cycles = 3'(cyc); start = 1;
    @(negedge clk);
    start = 0;
    if (exp_res == 3) begin
      chk(done && result == 2'd3, "R1", {done, result}, 7);
      chk(!busy, "R1", busy, 0);
    end else begin
      if (poke) begin
        repeat (3) @(negedge clk);
        first_blk = 16'd9; last_blk = 16'd9; start = 1;
        @(negedge clk);
        start = 0;
      end
      while (!done) @(negedge clk);
      chk(result == 2'(exp_res), req, result, exp_res);
    end
    #1;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(ers_q.size() == 0, "R9", ers_q.size(), 0);
    exp_q.delete(); ers_q.delete();
    repeat (3) @(negedge clk);
    chk(!busy && bus_op == 2'd0, req, {busy, bus_op}, 0);
  endtask

  bit finished = 0;

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !erased_valid && bus_op == 2'd0, "R10", {busy, done, bus_op}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 R3 R4 R9 R10: small page, 2 row bytes, three blocks
    run(2, 4, 5, 0, 3, 0, 0, 0, "R4", 0);
    // R4: 3 row bytes, slow ready (R6)
    run(7, 7, 5, 0, 4, 3, 0, 0, "R6", 0);
    // R3 R4: 4 row bytes
    run(16'h1234, 16'h1235, 14, 0, 5, 1, 0, 0, "R3", 0);
    // R5: large page, 2 bytes at 4 cycles
    run(1, 2, 6, 1, 4, 2, 0, 0, "R5", 0);
    // R5: large page, 3 bytes at 5 cycles
    run(16'h03FF, 16'h03FF, 6, 1, 5, 0, 0, 0, "R5", 0);
    // R7 timeout
    run(5, 6, 6, 1, 5, 2000, 0, 1, "R7", 0);
    // R8 fail on second block
    run(0, 3, 5, 0, 3, 1, 2, 2, "R8", 0);
    // R1 bad arguments
    run(16'hFFFE, 3, 5, 0, 3, 0, 0, 3, "R1", 0);
    run(3, 16'h2000, 5, 0, 3, 0, 0, 3, "R1", 0);
    run(6, 5, 5, 0, 3, 0, 0, 3, "R1", 0);
    // R11 start while busy
    run(3, 4, 5, 0, 3, 2, 0, 0, "R11", 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule